// File: doc/BRIEF.md
# Shared-Line Interrupt/Reset Discriminator

This block sits on the module side of a single active-low, open-drain control wire that carries traffic in both directions. The module signals an interrupt by pulling the wire low for a bounded time. The host requests a reset by holding the same wire low for much longer. The block never drives the wire high. It only asserts an output-enable that pulls the wire low, and it reads back the resolved wire level. The external pull-up returns the wire high once every driver has let go.

An interrupt request input starts one low pulse of fixed, parameterised width. That width is checked at elaboration to lie strictly inside the legal interrupt window. Requests that arrive while the wire is busy collapse into one pending request, which is sent once the wire is free again. The incoming level passes through a synchroniser and a glitch filter. Each low period that the block did not drive is then timed with microsecond and millisecond tick dividers. A period long enough to be a reset produces a one-cycle reset pulse when the wire rises. A period too long for an interrupt but too short for a reset produces a one-cycle error pulse and has no other effect. All control pins are plain levels or single-cycle pulses. No data stream crosses the boundary, so there is no valid/ready handshake.

Top module: `irq_rst_line`

## Requirements
- R1: The block drives the wire only through `line_oe`, where 1 means pull low and 0 means release. `line_oe` stays 0 for the whole of any low period driven only by the host.
- R2: An interrupt pulse holds `line_oe` at 1 for exactly INT_PULSE_US × CYC_PER_US consecutive cycles. That width is at least INT_MIN_US and at most INT_MAX_US microseconds.
- R3: When the block is idle and the filtered wire is high, a request seen at a clock edge sets `line_oe` on that same edge, well within the 200 ms assertion limit.
- R4: After a pulse the wire is released. The block's own low periods never produce `rst_pulse` or `err_pulse`.
- R5: Requests that arrive during a pulse or its release guard are merged into one pending request. That request is sent as a single extra pulse no sooner than SYNC_STAGES+FILT_LEN+2 cycles after the release.
- R6: A request made while the host holds the wire low is deferred. `line_oe` stays 0 until the filtered wire has been seen high.
- R7: A host low period of at least RST_MIN_MS milliseconds gives exactly one one-cycle `rst_pulse` after the wire rises, and no `err_pulse`.
- R8: A host low period longer than INT_MAX_US microseconds but shorter than the reset threshold gives exactly one one-cycle `err_pulse`, and no `rst_pulse`.
- R9: A host low period no longer than INT_MAX_US microseconds gives neither pulse.
- R10: The glitch filter ignores wire excursions shorter than FILT_LEN cycles. A 2-cycle high blip inside a reset-length low does not split it, and a 2-cycle low glitch produces nothing.
- R11: After reset, `line_oe`, `rst_pulse` and `err_pulse` are all 0.
- R12: Elaboration stops with an error unless INT_MIN_US < INT_PULSE_US < INT_MAX_US and the reset threshold exceeds the interrupt maximum.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 1 | Request one interrupt pulse (level or single cycle) |
| line_in | input | 1 | Resolved level of the shared wire |
| line_oe | output | 1 | 1 pulls the wire low, 0 releases it |
| rst_pulse | output | 1 | One-cycle pulse: the host has completed a reset-length low |
| err_pulse | output | 1 | One-cycle pulse: a low of illegal intermediate length ended |

## Verification
The bench aims low periods just inside and just outside each threshold. A comparator with the wrong sense or a saturating counter that is too short would report a reset as an error, or the reverse. It places a short high blip inside a reset-length low and a short lone glitch on the wire. A missing or weak filter would split the reset or report stray events. It also fires interrupts back to back and during a host-held low. A design without the release guard would classify its own pulse tail. A design without pending logic would drop the second request. A design that ignores the wire would drive while the host holds it low.

// File: rtl/irq_line_pkg.sv
package irq_line_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_DRIVE = 2'd1,
    PH_GUARD = 2'd2
  } drv_phase_e;

  typedef struct packed {
    logic is_rst;
    logic is_err;
  } low_verdict_t;

  function automatic low_verdict_t judge_low(input logic rst_reached,
                                             input logic past_int_max);
    low_verdict_t v;
    v.is_rst = rst_reached;
    v.is_err = !rst_reached && past_int_max;
    return v;
  endfunction

endpackage

// File: rtl/irq_tick_div.sv
module irq_tick_div #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic tick
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt_q;

  generate
    if (DIV < 2) begin : g_bad_div
      $error("irq_tick_div: DIV must be at least 2");
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      cnt_q <= '0;
    end else if (en) begin
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  assign tick = en && !clr && (cnt_q == LAST);

endmodule

// File: rtl/irq_line_filter.sv
module irq_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic line_lo
);
  localparam int FW = $clog2(FILT_LEN);
  localparam logic [FW-1:0] RUN_LAST = FW'(FILT_LEN - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   synced;
  logic                   level_q;
  logic [FW-1:0]          run_q;

  generate
    if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("irq_line_filter: SYNC_STAGES must be at least 2");
    end
    if (FILT_LEN < 2) begin : g_bad_filt
      $error("irq_line_filter: FILT_LEN must be at least 2");
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], line_in};
  end

  assign synced = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level_q <= 1'b1;
      run_q   <= '0;
    end else if (synced == level_q) begin
      run_q <= '0;
    end else if (run_q == RUN_LAST) begin
      level_q <= synced;
      run_q   <= '0;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end

  assign line_lo = ~level_q;

  AST_FILT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (level_q != $past(level_q)) |-> ($past(synced) == level_q)) else $error("filter moved against input"); // R10

endmodule

// File: rtl/irq_pulse_drv.sv
module irq_pulse_drv
  import irq_line_pkg::*;
#(
  parameter int CYC_PER_US   = 100,
  parameter int INT_PULSE_US = 20,
  parameter int INT_MIN_US   = 5,
  parameter int INT_MAX_US   = 50,
  parameter int GUARD_CYC    = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_req,
  input  logic line_lo,
  output logic line_oe,
  output logic mask
);
  localparam int PW      = $clog2(INT_PULSE_US);
  localparam int GW      = $clog2(GUARD_CYC);
  localparam int MIN_CYC = INT_MIN_US * CYC_PER_US;
  localparam int MAX_CYC = INT_MAX_US * CYC_PER_US;
  localparam int RW      = $clog2(MAX_CYC + 2);
  localparam logic [PW-1:0] PUL_LAST   = PW'(INT_PULSE_US - 1);
  localparam logic [GW-1:0] GUARD_LAST = GW'(GUARD_CYC - 1);

  drv_phase_e    phase_q;
  logic          pending_q;
  logic [PW-1:0] pul_us_q;
  logic [GW-1:0] guard_q;
  logic          us_tick;
  logic          want;

  irq_tick_div #(.DIV(CYC_PER_US)) u_us_div (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (phase_q != PH_DRIVE),
    .en   (1'b1),
    .tick (us_tick)
  );

  assign want = pending_q | irq_req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      pending_q <= 1'b0;
      pul_us_q  <= '0;
      guard_q   <= '0;
    end else begin
      case (phase_q)
        PH_IDLE: begin
          if (want && !line_lo) begin
            phase_q   <= PH_DRIVE;
            pul_us_q  <= '0;
            pending_q <= 1'b0;
          end else begin
            pending_q <= want;
          end
        end
        PH_DRIVE: begin
          pending_q <= want;
          if (us_tick) begin
            if (pul_us_q == PUL_LAST) begin
              phase_q <= PH_GUARD;
              guard_q <= '0;
            end else begin
              pul_us_q <= pul_us_q + 1'b1;
            end
          end
        end
        PH_GUARD: begin
          pending_q <= want;
          if (guard_q == GUARD_LAST) phase_q <= PH_IDLE;
          else                       guard_q <= guard_q + 1'b1;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign line_oe = (phase_q == PH_DRIVE);
  assign mask    = (phase_q != PH_IDLE);

  // Independent run-length watch on the drive enable, for the width checks.
  logic [RW-1:0] oe_run_q;
  always_ff @(posedge clk) begin
    if (!rst_n)                          oe_run_q <= '0;
    else if (!line_oe)                   oe_run_q <= '0;
    else if (oe_run_q != RW'(MAX_CYC+1)) oe_run_q <= oe_run_q + 1'b1;
  end

  AST_PULSE_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    line_oe |-> (oe_run_q < RW'(MAX_CYC))) else $error("pulse too wide"); // R2
  AST_PULSE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(line_oe) && !line_oe) |-> (oe_run_q >= RW'(MIN_CYC))) else $error("pulse too narrow"); // R2
  AST_START_LINE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_oe) |-> !$past(line_lo)) else $error("drove into held line"); // R6
  AST_GUARD_AFTER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(line_oe) |-> mask) else $error("mask dropped at release"); // R4

endmodule

// File: rtl/irq_low_timer.sv
module irq_low_timer
  import irq_line_pkg::*;
#(
  parameter int CYC_PER_US = 100,
  parameter int US_PER_MS  = 1000,
  parameter int INT_MAX_US = 50,
  parameter int RST_MIN_MS = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_lo,
  input  logic mask,
  output logic rst_pulse,
  output logic err_pulse
);
  localparam int UW = $clog2(INT_MAX_US + 2);
  localparam int MW = $clog2(RST_MIN_MS + 1);
  localparam logic [UW-1:0] US_SAT = UW'(INT_MAX_US + 1);
  localparam logic [MW-1:0] MS_SAT = MW'(RST_MIN_MS);

  logic          active_q;
  logic          us_tick, ms_tick;
  logic [UW-1:0] us_cnt_q;
  logic [MW-1:0] ms_cnt_q;
  low_verdict_t  verdict;

  irq_tick_div #(.DIV(CYC_PER_US)) u_us_div (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (!active_q),
    .en   (active_q),
    .tick (us_tick)
  );

  irq_tick_div #(.DIV(US_PER_MS)) u_ms_div (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (!active_q),
    .en   (us_tick),
    .tick (ms_tick)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || !active_q) begin
      us_cnt_q <= '0;
      ms_cnt_q <= '0;
    end else begin
      if (us_tick && us_cnt_q != US_SAT) us_cnt_q <= us_cnt_q + 1'b1;
      if (ms_tick && ms_cnt_q != MS_SAT) ms_cnt_q <= ms_cnt_q + 1'b1;
    end
  end

  assign verdict = judge_low(ms_cnt_q == MS_SAT, us_cnt_q == US_SAT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q  <= 1'b0;
      rst_pulse <= 1'b0;
      err_pulse <= 1'b0;
    end else begin
      rst_pulse <= 1'b0;
      err_pulse <= 1'b0;
      if (mask) begin
        active_q <= 1'b0;
      end else if (!active_q) begin
        active_q <= line_lo;
      end else if (!line_lo) begin
        active_q  <= 1'b0;
        rst_pulse <= verdict.is_rst;
        err_pulse <= verdict.is_err;
      end
    end
  end

  AST_VERDICT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rst_pulse && err_pulse)) else $error("both verdicts"); // R8
  AST_RST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pulse |=> !rst_pulse) else $error("reset pulse stretched"); // R7
  AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |=> !err_pulse) else $error("error pulse stretched"); // R8
  AST_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    mask |=> !(rst_pulse || err_pulse)) else $error("own pulse classified"); // R4

endmodule

// File: rtl/irq_rst_line.sv
module irq_rst_line #(
  parameter int CYC_PER_US   = 100,
  parameter int US_PER_MS    = 1000,
  parameter int INT_PULSE_US = 20,
  parameter int INT_MIN_US   = 5,
  parameter int INT_MAX_US   = 50,
  parameter int RST_MIN_MS   = 25,
  parameter int SYNC_STAGES  = 2,
  parameter int FILT_LEN     = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_req,
  input  logic line_in,
  output logic line_oe,
  output logic rst_pulse,
  output logic err_pulse
);
  localparam int GUARD_CYC = SYNC_STAGES + FILT_LEN + 2;

  // R12: legal interrupt width and ordered thresholds.
  generate
    if (!(INT_MIN_US < INT_PULSE_US && INT_PULSE_US < INT_MAX_US)) begin : g_bad_pulse
      $error("irq_rst_line: INT_PULSE_US outside the interrupt window");
    end
    if (RST_MIN_MS * US_PER_MS <= INT_MAX_US) begin : g_bad_rst
      $error("irq_rst_line: reset threshold not above interrupt maximum");
    end
  endgenerate

  logic line_lo;
  logic mask;

  irq_line_filter #(
    .SYNC_STAGES(SYNC_STAGES),
    .FILT_LEN   (FILT_LEN)
  ) u_filter (
    .clk    (clk),
    .rst_n  (rst_n),
    .line_in(line_in),
    .line_lo(line_lo)
  );

  irq_pulse_drv #(
    .CYC_PER_US  (CYC_PER_US),
    .INT_PULSE_US(INT_PULSE_US),
    .INT_MIN_US  (INT_MIN_US),
    .INT_MAX_US  (INT_MAX_US),
    .GUARD_CYC   (GUARD_CYC)
  ) u_drv (
    .clk    (clk),
    .rst_n  (rst_n),
    .irq_req(irq_req),
    .line_lo(line_lo),
    .line_oe(line_oe),
    .mask   (mask)
  );

  irq_low_timer #(
    .CYC_PER_US(CYC_PER_US),
    .US_PER_MS (US_PER_MS),
    .INT_MAX_US(INT_MAX_US),
    .RST_MIN_MS(RST_MIN_MS)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_lo  (line_lo),
    .mask     (mask),
    .rst_pulse(rst_pulse),
    .err_pulse(err_pulse)
  );

  AST_NO_DRIVE_IN_RESET: assert property (@(posedge clk)
    !rst_n |=> !line_oe) else $error("drive out of reset"); // R11

endmodule

// File: tb/irq_rst_line_tb.sv
module irq_rst_line_tb_top;
  localparam int CLK_P = 10;
  localparam int NV    = 7;
  // Scaled timing: 2 cycles per us, 10 us per ms -> interrupt max 100 cycles,
  // reset threshold 500 cycles, interrupt pulse 40 cycles.
  localparam int V_LOW  [NV] = '{60, 140, 480, 530, 530, 2, 1200};
  localparam int V_BLIP [NV] = '{0, 0, 0, 0, 250, 0, 0};
  localparam int V_RST  [NV] = '{0, 0, 0, 1, 1, 0, 1};
  localparam int V_ERR  [NV] = '{0, 1, 1, 0, 0, 0, 0};
  localparam int V_REQ  [NV] = '{9, 8, 8, 7, 10, 10, 7};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic irq_req = 1'b0;
  logic host_lo = 1'b0;
  logic line_in;
  logic line_oe, rst_pulse, err_pulse;

  int checks = 0;
  int errors = 0;
  int n_rst, n_err, n_oe, w, gap, rises, lat;
  logic prev_oe;

  always #(CLK_P/2) clk = ~clk;
  assign line_in = ~(line_oe | host_lo);

  irq_rst_line #(.CYC_PER_US(2), .US_PER_MS(10)) dut_i (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .line_in(line_in),
    .line_oe(line_oe), .rst_pulse(rst_pulse), .err_pulse(err_pulse)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic watch(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      n_rst += int'(rst_pulse);
      n_err += int'(err_pulse);
      n_oe  += int'(line_oe);
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check(line_oe == 1'b0, "R11 oe", int'(line_oe), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(rst_pulse == 1'b0 && err_pulse == 1'b0, "R11 pulses", int'(rst_pulse | err_pulse), 0);
    watch(10);

    // Host-driven low periods from the table.
    for (int v = 0; v < NV; v++) begin
      n_rst = 0; n_err = 0; n_oe = 0;
      for (int c = 0; c < V_LOW[v]; c++) begin
        @(negedge clk);
        n_rst += int'(rst_pulse); n_err += int'(err_pulse); n_oe += int'(line_oe);
        host_lo = !(V_BLIP[v] != 0 && c >= V_BLIP[v] && c < V_BLIP[v] + 2);
      end
      @(negedge clk);
      host_lo = 1'b0;
      watch(20);
      check(n_rst == V_RST[v], $sformatf("R%0d vec%0d rst", V_REQ[v], v), n_rst, V_RST[v]);
      check(n_err == V_ERR[v], $sformatf("R%0d vec%0d err", V_REQ[v], v), n_err, V_ERR[v]);
      check(n_oe == 0, $sformatf("R1 vec%0d oe", v), n_oe, 0);
    end

    // Single interrupt: latency, width, quiet tail.
    @(negedge clk);
    irq_req = 1'b1;
    check(line_oe == 1'b0, "R3 before edge", int'(line_oe), 0);
    @(negedge clk);
    irq_req = 1'b0;
    check(line_oe == 1'b1, "R3 start", int'(line_oe), 1);
    w = 1;
    while (line_oe && w < 300) begin @(negedge clk); if (line_oe) w++; end
    check(w == 40, "R2 width", w, 40);
    n_rst = 0; n_err = 0; n_oe = 0;
    watch(40);
    check(n_rst == 0 && n_err == 0, "R4 own pulse", n_rst + n_err, 0);
    check(n_oe == 0, "R4 released", n_oe, 0);

    // Back-to-back requests collapse to one extra pulse.
    @(negedge clk); irq_req = 1'b1;
    @(negedge clk); irq_req = 1'b0;
    repeat (10) @(negedge clk);
    irq_req = 1'b1;
    repeat (3) @(negedge clk);
    irq_req = 1'b0;
    rises = 1; gap = 0; prev_oe = 1'b1; n_rst = 0; n_err = 0;
    for (int i = 0; i < 250; i++) begin
      @(negedge clk);
      n_rst += int'(rst_pulse); n_err += int'(err_pulse);
      if (line_oe && !prev_oe) rises++;
      if (!line_oe && rises == 1) gap++;
      prev_oe = line_oe;
    end
    check(rises == 2, "R5 pulse count", rises, 2);
    check(gap >= 7 && gap <= 12, "R5 guard gap", gap, 8);
    check(n_rst == 0 && n_err == 0, "R4 two pulses quiet", n_rst + n_err, 0);

    // Request while host holds the line low.
    @(negedge clk); host_lo = 1'b1;
    repeat (5) @(negedge clk);
    irq_req = 1'b1;
    @(negedge clk); irq_req = 1'b0;
    n_oe = 0; n_rst = 0; n_err = 0;
    watch(54);
    check(n_oe == 0, "R6 deferred", n_oe, 0);
    host_lo = 1'b0;
    lat = 0;
    while (!line_oe && lat < 50) begin @(negedge clk); lat++; end
    check(lat >= 5 && lat <= 8, "R6 start after release", lat, 6);
    watch(80);
    check(n_rst == 0 && n_err == 0, "R9 short host low", n_rst + n_err, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule